// File: doc/BRIEF.md
# PHY Management Command Sequencer

This block carries out one PHY management register transfer (read or write) for a host. It talks to a simple serial-management master through three 16-bit registers: a command register, a data register and an interrupt-source register. The serial bit shifter behind those registers is a separate block.

Each transfer runs in a fixed order:
1. Acknowledge the interrupt source.
2. Wait for any earlier command to drain, and force an abort if that command never finishes.
3. Load the write data and issue the command.
4. Poll for completion within a bounded number of tries.
5. Fetch the read data.
6. Check the error flag in the interrupt source.

A failed transfer returns an all-ones word and raises an error flag. All waits are counted in microseconds, and the microsecond tick is derived from a clock-frequency parameter.

The host offers a request with `req_valid` and holds the fields steady until `req_ack`. The block ignores further requests until its single-cycle `rsp_done` pulse.

Top module: `mdio_cmd_seq`

## Requirements
- R1: After reset, `req_ack`, `rsp_done`, `rsp_err`, `mb_rd` and `mb_wr` are low and `rsp_rdata` is 0x0000.
- R2: While idle, a high `req_valid` gives a one-cycle `req_ack`, and the block captures the request fields in that cycle.
- R3: From acceptance until `rsp_done`, `req_valid` gives no `req_ack`, and changes on the request inputs do not alter the transfer in flight.
- R4: Before any command is issued, the block reads the interrupt-source register (`mb_sel`=2) once and writes the same value back. An error bit left over from earlier does not affect the result.
- R5: Before issuing, the block reads the command register (`mb_sel`=0) and checks bit 15 (busy). It reads at most PRE_TRIES times, with POLL_US microseconds between reads, and proceeds at the first read that shows bit 15 clear.
- R6: If bit 15 is still set on the PRE_TRIES-th read, the block writes 0x8000 (bit 15 = abort) to the command register. It then makes no register access for ABORT_US microseconds, and after that continues the transfer normally.
- R7: For a write, the block writes the data register (`mb_sel`=1) with the write data before the command word. The command word has bit 15 = 0 (start), bit 10 = 1 for write and 0 for read, bits 9:5 = PHY address, bits 4:0 = register number, and all other bits zero.
- R8: After issuing, the block waits POLL_US microseconds before each command-register read and makes at most POST_TRIES reads. If busy never clears, it ends with 0xFFFF and error set, and makes no data-register or interrupt-source access after the issue.
- R9: A read that completes without error returns the data-register contents. A write that completes without error returns 0x0000. In both cases the error flag is low.
- R10: After completion, the block reads the interrupt source and writes the same value back. If bit 0 (management error) is set, the result is 0xFFFF with error set.
- R11: `rsp_done` lasts exactly one cycle. Whenever `rsp_done` and `rsp_err` are both high, `rsp_rdata` is 0xFFFF.
- R12: `mb_rd` and `mb_wr` are never high in the same cycle. Read data on `mb_rdata` is taken in the same cycle as `mb_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request pending |
| req_ack | output | 1 | Request accepted this cycle |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | PHY register number |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, 0x0000 for a write, 0xFFFF on failure |
| rsp_err | output | 1 | Timeout or management error |
| mb_rd | output | 1 | Management register read strobe |
| mb_wr | output | 1 | Management register write strobe |
| mb_sel | output | 2 | Register select: 0 command, 1 data, 2 interrupt source |
| mb_wdata | output | 16 | Register write data |
| mb_rdata | input | 16 | Register read data, combinational from the master |

## Verification
The bench builds the block with CLK_MHZ=3, POLL_US=2, ABORT_US=5, PRE_TRIES=4 and POST_TRIES=6. With these values a poll interval is six clocks, so the forced abort after four busy reads and the timeout after six completion reads both happen within a few dozen cycles. A stuck-busy preload, an over-long operation and an injected error bit can therefore each be driven to its limit. The model master counts reads per phase and measures the quiet gap after an abort, which exposes off-by-one retry counts and a shortened abort delay.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

  localparam int unsigned BUSY_BIT = 15;
  localparam int unsigned RW_BIT   = 10;
  localparam int unsigned MERR_BIT = 0;
  localparam logic [15:0] FAIL_WORD  = 16'hFFFF;
  localparam logic [15:0] ABORT_WORD = 16'h8000;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_DATA = 2'd1,
    SEL_ISR  = 2'd2
  } mreg_sel_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CLR_RD, S_CLR_WR, S_PRE_RD, S_PRE_WAIT, S_ABORT, S_ABORT_WAIT,
    S_LOAD, S_ISSUE, S_POST_WAIT, S_POST_RD, S_FETCH, S_CHK_RD, S_CHK_WR, S_DONE
  } seq_state_e;

  // start command: busy/abort bit low, direction bit, address fields
  function automatic logic [15:0] make_cmd(input logic wr, input logic [4:0] phy,
                                           input logic [4:0] rg);
    logic [15:0] w;
    w = '0;
    w[RW_BIT] = wr;
    w[9:5]    = phy;
    w[4:0]    = rg;
    return w;
  endfunction

  // final response word after the completion check
  function automatic logic [15:0] finish_word(input logic merr, input logic wr,
                                              input logic [15:0] data);
    if (merr) return FAIL_WORD;
    if (wr)   return 16'h0000;
    return data;
  endfunction

endpackage

// File: rtl/mseq_us_timer.sv
module mseq_us_timer #(
  parameter int unsigned CLK_MHZ = 125,
  parameter int unsigned US_W    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [US_W-1:0] load_us,
  output logic            busy,
  output logic            fire
);
  localparam int unsigned PW = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;
  localparam logic [PW-1:0] PMAX = PW'(CLK_MHZ - 1);

  logic [PW-1:0]   pre_q;
  logic [US_W-1:0] rem_q;
  logic            run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      rem_q <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      pre_q <= '0;
      rem_q <= load_us;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (pre_q == PMAX) begin
        pre_q <= '0;
        rem_q <= rem_q - 1'b1;
        if (rem_q == US_W'(1)) run_q <= 1'b0;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign busy = run_q;
  assign fire = run_q && (pre_q == PMAX) && (rem_q == US_W'(1));

endmodule

// File: rtl/mseq_try_ctr.sv
module mseq_try_ctr #(
  parameter int unsigned LIMIT = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  // high during the LIMIT-th attempt
  assign last = (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/mdio_cmd_seq.sv
module mdio_cmd_seq
  import mseq_pkg::*;
#(
  parameter int unsigned CLK_MHZ    = 125,
  parameter int unsigned POLL_US    = 10,
  parameter int unsigned ABORT_US   = 100,
  parameter int unsigned PRE_TRIES  = 30,
  parameter int unsigned POST_TRIES = 300
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ack,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  input  logic        req_write,
  output logic        rsp_done,
  output logic [15:0] rsp_rdata,
  output logic        rsp_err,
  output logic        mb_rd,
  output logic        mb_wr,
  output logic [1:0]  mb_sel,
  output logic [15:0] mb_wdata,
  input  logic [15:0] mb_rdata
);
  localparam int unsigned MAX_US = (POLL_US > ABORT_US) ? POLL_US : ABORT_US;
  localparam int unsigned US_W   = $clog2(MAX_US + 1);

  seq_state_e  st_q, st_n;
  logic [4:0]  phy_q, reg_q;
  logic [15:0] wd_q, isr_q, data_q, res_q;
  logic        wr_q, err_q;

  logic            tmr_start, tmr_fire, tmr_busy;
  logic [US_W-1:0] tmr_load;
  logic            pre_clr, pre_inc, pre_last;
  logic            post_clr, post_inc, post_last;
  logic            timeout_evt;

  // named events for the checker
  logic abort_evt, issue_evt;
  assign abort_evt = (st_q == S_ABORT);
  assign issue_evt = (st_q == S_ISSUE);

  mseq_us_timer #(.CLK_MHZ(CLK_MHZ), .US_W(US_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .load_us(tmr_load),
    .busy(tmr_busy), .fire(tmr_fire)
  );

  mseq_try_ctr #(.LIMIT(PRE_TRIES)) u_pre_ctr (
    .clk(clk), .rst_n(rst_n), .clr(pre_clr), .inc(pre_inc), .last(pre_last)
  );

  mseq_try_ctr #(.LIMIT(POST_TRIES)) u_post_ctr (
    .clk(clk), .rst_n(rst_n), .clr(post_clr), .inc(post_inc), .last(post_last)
  );

  always_comb begin
    st_n        = st_q;
    mb_rd       = 1'b0;
    mb_wr       = 1'b0;
    mb_sel      = SEL_CMD;
    mb_wdata    = '0;
    tmr_start   = 1'b0;
    tmr_load    = US_W'(POLL_US);
    pre_clr     = 1'b0;
    pre_inc     = 1'b0;
    post_clr    = 1'b0;
    post_inc    = 1'b0;
    timeout_evt = 1'b0;
    unique case (st_q)
      S_IDLE: if (req_valid) begin
        st_n    = S_CLR_RD;
        pre_clr = 1'b1;
      end
      S_CLR_RD: begin
        mb_rd  = 1'b1;
        mb_sel = SEL_ISR;
        st_n   = S_CLR_WR;
      end
      S_CLR_WR: begin
        mb_wr    = 1'b1;
        mb_sel   = SEL_ISR;
        mb_wdata = isr_q;
        st_n     = S_PRE_RD;
      end
      S_PRE_RD: begin
        mb_rd = 1'b1;
        if (!mb_rdata[BUSY_BIT]) begin
          st_n = wr_q ? S_LOAD : S_ISSUE;
        end else if (pre_last) begin
          st_n = S_ABORT;
        end else begin
          pre_inc   = 1'b1;
          tmr_start = 1'b1;
          st_n      = S_PRE_WAIT;
        end
      end
      S_PRE_WAIT: if (tmr_fire) st_n = S_PRE_RD;
      S_ABORT: begin
        mb_wr     = 1'b1;
        mb_wdata  = ABORT_WORD;
        tmr_start = 1'b1;
        tmr_load  = US_W'(ABORT_US);
        st_n      = S_ABORT_WAIT;
      end
      S_ABORT_WAIT: if (tmr_fire) st_n = wr_q ? S_LOAD : S_ISSUE;
      S_LOAD: begin
        mb_wr    = 1'b1;
        mb_sel   = SEL_DATA;
        mb_wdata = wd_q;
        st_n     = S_ISSUE;
      end
      S_ISSUE: begin
        mb_wr     = 1'b1;
        mb_wdata  = make_cmd(wr_q, phy_q, reg_q);
        tmr_start = 1'b1;
        post_clr  = 1'b1;
        st_n      = S_POST_WAIT;
      end
      S_POST_WAIT: if (tmr_fire) st_n = S_POST_RD;
      S_POST_RD: begin
        mb_rd = 1'b1;
        if (!mb_rdata[BUSY_BIT]) begin
          st_n = wr_q ? S_CHK_RD : S_FETCH;
        end else if (post_last) begin
          timeout_evt = 1'b1;
          st_n        = S_DONE;
        end else begin
          post_inc  = 1'b1;
          tmr_start = 1'b1;
          st_n      = S_POST_WAIT;
        end
      end
      S_FETCH: begin
        mb_rd  = 1'b1;
        mb_sel = SEL_DATA;
        st_n   = S_CHK_RD;
      end
      S_CHK_RD: begin
        mb_rd  = 1'b1;
        mb_sel = SEL_ISR;
        st_n   = S_CHK_WR;
      end
      S_CHK_WR: begin
        mb_wr    = 1'b1;
        mb_sel   = SEL_ISR;
        mb_wdata = isr_q;
        st_n     = S_DONE;
      end
      S_DONE:  st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      phy_q  <= '0;
      reg_q  <= '0;
      wd_q   <= '0;
      wr_q   <= 1'b0;
      isr_q  <= '0;
      data_q <= '0;
      res_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q <= st_n;
      if (st_q == S_IDLE && req_valid) begin
        phy_q  <= req_phy;
        reg_q  <= req_reg;
        wd_q   <= req_wdata;
        wr_q   <= req_write;
        data_q <= '0;
      end
      if (st_q == S_CLR_RD || st_q == S_CHK_RD) isr_q <= mb_rdata;
      if (st_q == S_FETCH) data_q <= mb_rdata;
      if (timeout_evt) begin
        res_q <= FAIL_WORD;
        err_q <= 1'b1;
      end
      if (st_q == S_CHK_WR) begin
        res_q <= finish_word(isr_q[MERR_BIT], wr_q, data_q);
        err_q <= isr_q[MERR_BIT];
      end
    end
  end

  assign req_ack   = (st_q == S_IDLE) && req_valid;
  assign rsp_done  = (st_q == S_DONE);
  assign rsp_rdata = res_q;
  assign rsp_err   = err_q;

endmodule

// File: rtl/mdio_cmd_seq_chk.sv
module mdio_cmd_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ack,
  input logic        rsp_done,
  input logic        rsp_err,
  input logic [15:0] rsp_rdata,
  input logic        mb_rd,
  input logic        mb_wr,
  input logic        abort_evt,
  input logic        issue_evt,
  input logic        tmr_busy
);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R11
  err_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_err) |-> (rsp_rdata == 16'hFFFF));

  // R3
  single_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);

  // R2
  ack_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ack && rsp_done));

  // R12
  bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mb_rd && mb_wr));

  // R6
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (tmr_busy && !mb_rd && !mb_wr));

  // R8
  issue_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_evt |=> (tmr_busy && !mb_rd && !mb_wr));

endmodule

bind mdio_cmd_seq mdio_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ack(req_ack), .rsp_done(rsp_done),
  .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .mb_rd(mb_rd), .mb_wr(mb_wr),
  .abort_evt(abort_evt), .issue_evt(issue_evt), .tmr_busy(tmr_busy)
);

// File: tb/mdio_cmd_seq_test.sv
module mdio_cmd_seq_test;

  localparam int CM = 3;
  localparam int PU = 2;
  localparam int AU = 5;
  localparam int PT = 4;
  localparam int QT = 6;

  typedef struct packed {
    logic        wr;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] wd;
    logic [15:0] pre;
    logic [15:0] lat;
    logic        ierr;
    logic [15:0] isr;
    logic        ab;
    logic        to;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 5'd1,  5'd2,  16'h0000, 16'd0,    16'd3,   1'b0, 16'h0000, 1'b0, 1'b0},
    '{1'b1, 5'd31, 5'd0,  16'hA5C3, 16'd0,    16'd20,  1'b0, 16'h0000, 1'b0, 1'b0},
    '{1'b0, 5'd5,  5'd17, 16'h0000, 16'd10,   16'd20,  1'b0, 16'h0006, 1'b0, 1'b0},
    '{1'b0, 5'd2,  5'd3,  16'h0000, 16'd5000, 16'd3,   1'b0, 16'h0000, 1'b1, 1'b0},
    '{1'b0, 5'd7,  5'd9,  16'h0000, 16'd0,    16'd400, 1'b0, 16'h0000, 1'b0, 1'b1},
    '{1'b0, 5'd3,  5'd1,  16'h0000, 16'd0,    16'd3,   1'b1, 16'h0000, 1'b0, 1'b0},
    '{1'b1, 5'd9,  5'd30, 16'h1234, 16'd0,    16'd3,   1'b0, 16'h0001, 1'b0, 1'b0},
    '{1'b1, 5'd4,  5'd4,  16'hFFFF, 16'd5000, 16'd400, 1'b0, 16'h0000, 1'b1, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ack;
  logic [4:0]  req_phy = '0;
  logic [4:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        req_write = 1'b0;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic        rsp_err;
  logic        mb_rd, mb_wr;
  logic [1:0]  mb_sel;
  logic [15:0] mb_wdata;
  logic [15:0] mb_rdata;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  mdio_cmd_seq #(
    .CLK_MHZ(CM), .POLL_US(PU), .ABORT_US(AU), .PRE_TRIES(PT), .POST_TRIES(QT)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ack(req_ack),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .req_write(req_write), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .mb_rd(mb_rd), .mb_wr(mb_wr), .mb_sel(mb_sel),
    .mb_wdata(mb_wdata), .mb_rdata(mb_rdata)
  );

  // ---------------- model management master ----------------
  logic        pl_go = 1'b0;
  logic [15:0] pl_busy = '0, pl_isr = '0, cfg_lat = 16'd3;
  logic        cfg_err = 1'b0;

  logic        m_busy = 1'b0, op_act = 1'b0, op_wr = 1'b0, issued = 1'b0;
  logic        abort_pend = 1'b0, data_wr_pre = 1'b0;
  logic [15:0] left = '0, m_isr = '0, m_data = '0, cmd_word = '0, data_at_issue = '0;
  logic [15:0] isr_wb_val = '0;
  int cyc = 0, abort_cyc = 0, gap = 0;
  int pre_rd = 0, post_rd = 0, abort_cnt = 0, isr_rd_pre = 0, isr_wb_cnt = 0;
  int data_rd_after = 0, isr_after = 0;

  function automatic logic [15:0] pat(input logic [4:0] p, input logic [4:0] r);
    return {r, p, 1'b1, ~p};
  endfunction

  assign mb_rdata = (mb_sel == 2'd0) ? {m_busy, cmd_word[14:0]} :
                    (mb_sel == 2'd1) ? m_data : m_isr;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (pl_go) begin
      m_busy <= (pl_busy != 0); left <= pl_busy; m_isr <= pl_isr;
      op_act <= 1'b0; issued <= 1'b0; abort_pend <= 1'b0; data_wr_pre <= 1'b0;
      pre_rd <= 0; post_rd <= 0; abort_cnt <= 0; isr_rd_pre <= 0; isr_wb_cnt <= 0;
      data_rd_after <= 0; isr_after <= 0; gap <= 0; isr_wb_val <= '0;
    end else begin
      if (m_busy && left != 0) begin
        left <= left - 1'b1;
        if (left == 16'd1) begin
          m_busy <= 1'b0;
          if (op_act) begin
            if (!op_wr) m_data <= pat(cmd_word[9:5], cmd_word[4:0]);
            if (cfg_err) m_isr <= m_isr | 16'h0001;
            op_act <= 1'b0;
          end
        end
      end
      if (abort_pend && (mb_rd || mb_wr)) begin
        gap <= cyc - abort_cyc;
        abort_pend <= 1'b0;
      end
      if (mb_rd) begin
        case (mb_sel)
          2'd0: if (!issued) pre_rd <= pre_rd + 1; else post_rd <= post_rd + 1;
          2'd1: if (issued) data_rd_after <= data_rd_after + 1;
          default: if (issued) isr_after <= isr_after + 1; else isr_rd_pre <= isr_rd_pre + 1;
        endcase
      end
      if (mb_wr) begin
        case (mb_sel)
          2'd0: if (mb_wdata[15]) begin
            m_busy <= 1'b0; op_act <= 1'b0; abort_cnt <= abort_cnt + 1;
            abort_cyc <= cyc; abort_pend <= 1'b1;
          end else begin
            issued <= 1'b1; cmd_word <= mb_wdata; m_busy <= 1'b1; left <= cfg_lat;
            op_act <= 1'b1; op_wr <= mb_wdata[10]; data_at_issue <= m_data;
          end
          2'd1: begin
            m_data <= mb_wdata;
            if (!issued) data_wr_pre <= 1'b1;
          end
          default: begin
            m_isr <= m_isr & ~mb_wdata;
            if (issued) isr_after <= isr_after + 1;
            else begin isr_wb_val <= mb_wdata; isr_wb_cnt <= isr_wb_cnt + 1; end
          end
        endcase
      end
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input bit hold);
    bit ack_seen;
    bit got;
    int extra_acks;
    logic [15:0] rd, exp_rd;
    logic e, exp_e;
    @(negedge clk);
    cfg_lat = v.lat; cfg_err = v.ierr; pl_busy = v.pre; pl_isr = v.isr; pl_go = 1'b1;
    @(negedge clk);
    pl_go = 1'b0;
    req_phy = v.phy; req_reg = v.rg; req_wdata = v.wd; req_write = v.wr; req_valid = 1'b1;
    #2 ack_seen = req_ack;
    check(ack_seen, "R2 ack on idle request", int'(ack_seen), 1);
    @(negedge clk);
    extra_acks = 0;
    if (hold) begin
      req_phy = 5'd30; req_reg = 5'd29; req_wdata = 16'hDEAD; req_write = ~v.wr;
    end else begin
      req_valid = 1'b0;
    end
    got = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (rsp_done) begin got = 1'b1; break; end
      if (req_ack) extra_acks++;
      @(negedge clk);
    end
    rd = rsp_rdata; e = rsp_err;
    req_valid = 1'b0;
    check(got, "R9 completion reached", int'(got), 1);
    if (hold) check(extra_acks == 0, "R3 busy requests ignored", extra_acks, 0);
    if (v.to || v.ierr) begin exp_rd = 16'hFFFF; exp_e = 1'b1; end
    else if (v.wr)      begin exp_rd = 16'h0000; exp_e = 1'b0; end
    else                begin exp_rd = pat(v.phy, v.rg); exp_e = 1'b0; end
    check(rd == exp_rd, v.to ? "R8 timeout word" : (v.ierr ? "R10 error word" : "R9 result data"),
          int'(rd), int'(exp_rd));
    check(e == exp_e, "R10 error flag", int'(e), int'(exp_e));
    check(cmd_word == {5'b0, v.wr, v.phy, v.rg}, "R7 command word layout",
          int'(cmd_word), int'({5'b0, v.wr, v.phy, v.rg}));
    if (v.wr) begin
      check(data_wr_pre, "R7 data loaded before command", int'(data_wr_pre), 1);
      check(data_at_issue == v.wd, "R7 data at issue", int'(data_at_issue), int'(v.wd));
    end
    check(isr_rd_pre == 1 && isr_wb_cnt == 1, "R4 single read and write-back",
          isr_wb_cnt, 1);
    check(isr_wb_val == v.isr, "R4 write-back value", int'(isr_wb_val), int'(v.isr));
    if (v.ab) begin
      check(pre_rd == PT, "R6 busy reads before abort", pre_rd, PT);
      check(abort_cnt == 1, "R6 abort written", abort_cnt, 1);
      check(gap >= AU * CM, "R6 quiet gap after abort", gap, AU * CM);
    end else begin
      check(abort_cnt == 0, "R5 no abort", abort_cnt, 0);
      if (v.pre == 0) check(pre_rd == 1, "R5 single clear read", pre_rd, 1);
      else check(pre_rd >= 2 && pre_rd < PT, "R5 poll until clear", pre_rd, 2);
    end
    if (v.to) begin
      check(post_rd == QT, "R8 completion reads", post_rd, QT);
      check(data_rd_after == 0 && isr_after == 0, "R8 no access after timeout",
            data_rd_after + isr_after, 0);
    end else begin
      check(isr_after == 2, "R10 interrupt source checked", isr_after, 2);
      check(data_rd_after == (v.wr ? 0 : 1), "R9 data fetch", data_rd_after, v.wr ? 0 : 1);
    end
    @(negedge clk);
    check(!rsp_done, "R11 done lasts one cycle", int'(rsp_done), 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!req_ack && !rsp_done && !rsp_err, "R1 reset outputs",
          int'({req_ack, rsp_done, rsp_err}), 0);
    check(rsp_rdata == 16'h0000, "R1 reset data", int'(rsp_rdata), 0);
    check(!mb_rd && !mb_wr, "R1 reset bus idle", int'({mb_rd, mb_wr}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!mb_rd && !mb_wr && !rsp_done, "R1 idle after reset",
          int'({mb_rd, mb_wr, rsp_done}), 0);

    for (int k = 0; k < NV; k++) run_vec(VECS[k], 1'b0);

    // R3 directed: request held with changed fields during a transfer
    run_vec('{1'b0, 5'd1, 5'd2, 16'h0000, 16'd0, 16'd20, 1'b0, 16'h0000, 1'b0, 1'b0}, 1'b1);
    check(cmd_word == {5'b0, 1'b0, 5'd1, 5'd2}, "R3 fields unchanged",
          int'(cmd_word), int'({5'b0, 1'b0, 5'd1, 5'd2}));

    // R10 directed: error injected on a write
    run_vec('{1'b1, 5'd6, 5'd6, 16'h00FF, 16'd0, 16'd3, 1'b1, 16'h0000, 1'b0, 1'b0}, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule